// File: doc/BRIEF.md
# Interpolating Line-Buffer Reader

This block sits between a video capture path and a raster output. Captured pixels arrive on a write port and go into a small ring of line buffers. A raster generator supplies the visible output coordinate, a 4-bit sub-pixel phase in each direction, and its sync levels. For every output pixel the block reads three stored neighbours from one single-port memory: the sample at the current position, the sample on the next line, and the sample one column to the right. It then blends them linearly with rounding and saturation.

Each output pixel takes a fixed period of four memory clocks. Three slots carry the reads and the fourth carries a capture write. Writes wait in a short queue until a write slot comes up. While the raster is outside the visible area the block does no reads, and every clock drains the queue. The blended pixel, its valid flag and both syncs leave the block with a fixed latency of four output periods.

Top module: `interp_line_reader`

## Requirements
- R1: An output period is 4 clocks. `pix_ce` is high only in the last clock (slot 3) of each period, and the first period starts in the first clock after reset is released. The memory port performs at most one access per clock.
- R2: Line y is stored in line slot (y mod 2^LINE_W), and the write address is {wr_line, wr_x}. For a visible position (x,y), let a = stored (x,y), b = stored (x,y+1) and r = stored (x+1,y), with `frac_h`/`frac_v` in sixteenths. The output is floor((16a + frac_h*(r-a) + frac_v*(b-a) + 8) / 16).
- R3: An R2 result below 0 is output as 0, and a result above 2^PIX_W-1 is output as 2^PIX_W-1.
- R4: At x = H_VIS-1, r is taken from (x,y) itself.
- R5: At y = V_VIS-1, b is taken from line y itself.
- R6: The inputs `out_x`, `out_y`, `frac_h`, `frac_v`, `hs_in` and `vs_in` are held for a whole period. The matching `pix_out`, `pix_valid`, `hs_out` and `vs_out` are present throughout the fourth period after it, and they change only at period boundaries.
- R7: A position with x >= H_VIS or y >= V_VIS gives `pix_valid` = 0 and `pix_out` = 0, and issues no memory reads.
- R8: Accepted writes (`wr_valid` and `wr_ready` high at a clock edge) wait in a WQ_DEPTH-entry queue. `wr_ready` is low only while the queue is full. Every accepted write reaches memory, in order.
- R9: During an invisible period every clock is a write slot, so a stream of one write per clock is never held off.
- R10: After reset, `pix_out` = 0, `pix_valid` = 0, `hs_out` = 0, `vs_out` = 0 and `wr_ready` = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Memory clock, four per output pixel |
| rst_n | input | 1 | Active-low synchronous reset |
| pix_ce | output | 1 | Last clock of an output period; raster advances after it |
| out_x | input | X_W | Output column |
| out_y | input | Y_W | Output line |
| frac_h | input | FRAC_W | Horizontal phase toward the right neighbour |
| frac_v | input | FRAC_W | Vertical phase toward the next line |
| hs_in | input | 1 | Horizontal sync level from the raster |
| vs_in | input | 1 | Vertical sync level from the raster |
| wr_valid | input | 1 | Capture pixel offered |
| wr_ready | output | 1 | Write queue can accept |
| wr_x | input | X_W | Capture column |
| wr_line | input | LINE_W | Capture line slot |
| wr_data | input | PIX_W | Capture pixel value |
| pix_out | output | PIX_W | Blended output pixel |
| pix_valid | output | 1 | Output pixel lies in the visible area |
| hs_out | output | 1 | Delayed horizontal sync |
| vs_out | output | 1 | Delayed vertical sync |

## Verification
The line buffers are filled with a stored pattern that mixes full-scale, zero and ramp values. The raster then sweeps every line with phases that change per column. This separates a neighbour fetched from the wrong line or column from a wrong weight. It also drives columns where a full-scale centre meets zero neighbours, and a mid value meets full-scale neighbours, at the largest phase; only correct clamping gives the right value at those points. The last column, the last line and an invisible line with sync pulses check the edge repeats, blanking and the four-period alignment of the syncs. A burst of back-to-back writes during the visible area must stall and must still show up intact in later lines, while the same burst in blanking must never stall.

// File: rtl/interp_line_reader.sv
module interp_line_reader #(
  parameter int PIX_W    = 8,
  parameter int X_W      = 9,
  parameter int Y_W      = 9,
  parameter int H_VIS    = 320,
  parameter int V_VIS    = 240,
  parameter int LINE_W   = 2,
  parameter int FRAC_W   = 4,
  parameter int WQ_DEPTH = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic              pix_ce,
  input  logic [X_W-1:0]    out_x,
  input  logic [Y_W-1:0]    out_y,
  input  logic [FRAC_W-1:0] frac_h,
  input  logic [FRAC_W-1:0] frac_v,
  input  logic              hs_in,
  input  logic              vs_in,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [X_W-1:0]    wr_x,
  input  logic [LINE_W-1:0] wr_line,
  input  logic [PIX_W-1:0]  wr_data,
  output logic [PIX_W-1:0]  pix_out,
  output logic              pix_valid,
  output logic              hs_out,
  output logic              vs_out
);
  localparam int AW    = LINE_W + X_W;
  localparam int DEPTH = 1 << AW;
  localparam int QPW   = (WQ_DEPTH > 1) ? $clog2(WQ_DEPTH) : 1;
  localparam int SW    = PIX_W + FRAC_W + 3;
  localparam logic [X_W-1:0]    XLAST = X_W'(H_VIS - 1);
  localparam logic [Y_W-1:0]    YLAST = Y_W'(V_VIS - 1);
  localparam logic [QPW:0]      QFULL = (QPW + 1)'(WQ_DEPTH);
  localparam logic signed [SW-1:0] HALF = SW'(1 << (FRAC_W - 1));
  localparam logic signed [SW-1:0] MAXV = SW'((1 << PIX_W) - 1);

  logic [1:0] slot;
  logic vis_now, rd_en, we, push;
  logic [X_W-1:0] xr;
  logic [Y_W-1:0] yb;
  logic [AW-1:0] raddr;
  logic [PIX_W-1:0] mem [DEPTH];
  logic [PIX_W-1:0] q;

  always_ff @(posedge clk)
    if (!rst_n) slot <= '0;
    else        slot <= slot + 2'd1;

  assign pix_ce  = (slot == 2'd3);
  assign vis_now = (out_x <= XLAST) && (out_y <= YLAST);
  assign xr      = (out_x == XLAST) ? out_x : out_x + 1'b1;
  assign yb      = (out_y == YLAST) ? out_y : out_y + 1'b1;

  always_comb
    case (slot)
      2'd0:    raddr = {out_y[LINE_W-1:0], out_x};
      2'd1:    raddr = {yb[LINE_W-1:0], out_x};
      default: raddr = {out_y[LINE_W-1:0], xr};
    endcase

  logic [AW-1:0]    fq_a [WQ_DEPTH];
  logic [PIX_W-1:0] fq_d [WQ_DEPTH];
  logic [QPW-1:0]   wp, rp;
  logic [QPW:0]     cnt;

  assign wr_ready = (cnt != QFULL);
  assign push     = wr_valid && wr_ready;
  assign we       = (pix_ce || !vis_now) && (cnt != '0);
  assign rd_en    = vis_now && !pix_ce;

  always_ff @(posedge clk)
    if (!rst_n) begin
      wp <= '0; rp <= '0; cnt <= '0;
    end else begin
      if (push) begin
        fq_a[wp] <= {wr_line, wr_x};
        fq_d[wp] <= wr_data;
        wp <= (wp == QPW'(WQ_DEPTH - 1)) ? '0 : wp + 1'b1;
      end
      if (we) rp <= (rp == QPW'(WQ_DEPTH - 1)) ? '0 : rp + 1'b1;
      case ({push, we})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end

  always_ff @(posedge clk)
    if (we)         mem[fq_a[rp]] <= fq_d[rp];
    else if (rd_en) q <= mem[raddr];

  logic [PIX_W-1:0]  s_a, s_b, a1, b1, r1, blend, p2, p3, p4;
  logic [FRAC_W-1:0] fh1, fv1;
  logic [3:0] vld_sr, hs_sr, vs_sr;

  always_ff @(posedge clk)
    if (!rst_n) begin
      s_a <= '0; s_b <= '0; a1 <= '0; b1 <= '0; r1 <= '0;
      fh1 <= '0; fv1 <= '0; p2 <= '0; p3 <= '0; p4 <= '0;
      vld_sr <= '0; hs_sr <= '0; vs_sr <= '0;
    end else begin
      if (slot == 2'd1) s_a <= q;
      if (slot == 2'd2) s_b <= q;
      if (pix_ce) begin
        a1 <= s_a; b1 <= s_b; r1 <= q;
        fh1 <= frac_h; fv1 <= frac_v;
        p2 <= vld_sr[0] ? blend : '0;
        p3 <= p2;
        p4 <= p3;
        vld_sr <= {vld_sr[2:0], vis_now};
        hs_sr  <= {hs_sr[2:0], hs_in};
        vs_sr  <= {vs_sr[2:0], vs_in};
      end
    end

  logic signed [SW-1:0] ea, eb, er, efh, efv, num, shq;
  always_comb begin
    ea  = SW'(a1);
    eb  = SW'(b1);
    er  = SW'(r1);
    efh = SW'(fh1);
    efv = SW'(fv1);
    num = (ea <<< FRAC_W) + efh * (er - ea) + efv * (eb - ea) + HALF;
    shq = num >>> FRAC_W;
    if (shq < 0)         blend = '0;
    else if (shq > MAXV) blend = '1;
    else                 blend = shq[PIX_W-1:0];
  end

  assign pix_out   = p4;
  assign pix_valid = vld_sr[3];
  assign hs_out    = hs_sr[3];
  assign vs_out    = vs_sr[3];

  AST_PORT_EXCL: assert property (@(posedge clk) disable iff (!rst_n) !(we && rd_en)); // R1
  AST_CE_SPACING: assert property (@(posedge clk) disable iff (!rst_n) pix_ce |=> !pix_ce); // R1
  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !pix_ce |=> ($stable(pix_out) && $stable(pix_valid))); // R6
  AST_BLANK_BLACK: assert property (@(posedge clk) disable iff (!rst_n) !pix_valid |-> (pix_out == '0)); // R7
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n) cnt <= QFULL); // R8
  AST_BLANK_DRAIN: assert property (@(posedge clk) disable iff (!rst_n) (!vis_now && cnt != '0) |=> (cnt <= $past(cnt))); // R9
endmodule

// File: tb/interp_line_reader_test.sv
module interp_line_reader_test;
  localparam int PW = 8, XW = 5, YW = 4, HV = 16, VV = 6, LW = 2, FW = 4, QD = 4;
  localparam int NP = 4096;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n, pix_ce, hs_in, vs_in, wr_valid, wr_ready, pix_valid, hs_out, vs_out;
  logic [XW-1:0] out_x, wr_x;
  logic [YW-1:0] out_y;
  logic [FW-1:0] frac_h, frac_v;
  logic [LW-1:0] wr_line;
  logic [PW-1:0] wr_data, pix_out;

  interp_line_reader #(.PIX_W(PW), .X_W(XW), .Y_W(YW), .H_VIS(HV), .V_VIS(VV),
    .LINE_W(LW), .FRAC_W(FW), .WQ_DEPTH(QD)) uut (
    .clk(clk), .rst_n(rst_n), .pix_ce(pix_ce), .out_x(out_x), .out_y(out_y),
    .frac_h(frac_h), .frac_v(frac_v), .hs_in(hs_in), .vs_in(vs_in),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_x(wr_x), .wr_line(wr_line),
    .wr_data(wr_data), .pix_out(pix_out), .pix_valid(pix_valid),
    .hs_out(hs_out), .vs_out(vs_out));

  typedef struct { int x; int y; int fh; int fv; bit hs; bit vs; } req_t;

  int checks = 0, fails = 0;
  int ref_mem [4][32];
  int e_pix [NP];
  bit e_val [NP], e_hs [NP], e_vs [NP];
  string e_tag [NP];
  req_t rq [$];
  bit go = 0;
  int dp = 0, cur = 0;

  function automatic int pat(int x, int l);
    case ((x + l) % 4)
      0: return 255;
      1: return 0;
      default: return (x * 37 + l * 11 + 5) % 256;
    endcase
  endfunction

  function automatic void expect_for(int idx, req_t r);
    int a, b, rr, n;
    e_hs[idx] = r.hs; e_vs[idx] = r.vs;
    if (r.x >= HV || r.y >= VV) begin
      e_pix[idx] = 0; e_val[idx] = 0; e_tag[idx] = "R7";
      return;
    end
    a  = ref_mem[r.y % 4][r.x];
    b  = ref_mem[((r.y == VV - 1) ? r.y : r.y + 1) % 4][r.x];
    rr = ref_mem[r.y % 4][(r.x == HV - 1) ? r.x : r.x + 1];
    n  = (16 * a + r.fh * (rr - a) + r.fv * (b - a) + 8) >>> 4;
    e_tag[idx] = (r.x == HV - 1) ? "R4" : (r.y == VV - 1) ? "R5" : "R2";
    if (n < 0)   begin n = 0;   e_tag[idx] = "R3"; end
    if (n > 255) begin n = 255; e_tag[idx] = "R3"; end
    e_pix[idx] = n; e_val[idx] = 1;
  endfunction

  // raster driver: one request per period, idle when nothing is queued
  initial begin
    req_t r;
    wait (go);
    forever begin
      @(negedge clk);
      if (pix_ce) begin
        @(posedge clk); #1;
        dp++;
        if (rq.size() > 0) r = rq.pop_front();
        else r = '{x: HV, y: 0, fh: 0, fv: 0, hs: 0, vs: 0};
        out_x = XW'(r.x); out_y = YW'(r.y);
        frac_h = FW'(r.fh); frac_v = FW'(r.fv);
        hs_in = r.hs; vs_in = r.vs;
        if (dp < NP) expect_for(dp, r);
      end
    end
  end

  // per-clock comparison against the model, four periods behind (R6)
  initial begin
    int gap, idx;
    bit seen;
    gap = 0; seen = 0;
    wait (go);
    forever begin
      @(negedge clk);
      idx = (cur >= 4) ? cur - 4 : 0;
      checks++;
      if (pix_out !== PW'(e_pix[idx]) || pix_valid !== e_val[idx]) begin
        fails++;
        $display("FAIL %s period %0d: pix=%0d valid=%0b expected pix=%0d valid=%0b",
                 e_tag[idx], cur, pix_out, pix_valid, e_pix[idx], e_val[idx]);
      end
      checks++;
      if (hs_out !== e_hs[idx] || vs_out !== e_vs[idx]) begin
        fails++;
        $display("FAIL R6 period %0d: hs=%0b vs=%0b expected hs=%0b vs=%0b",
                 cur, hs_out, vs_out, e_hs[idx], e_vs[idx]);
      end
      gap++;
      if (pix_ce) begin
        if (seen) begin
          checks++;
          if (gap != 4) begin
            fails++;
            $display("FAIL R1 period length %0d expected 4", gap);
          end
        end
        seen = 1; gap = 0; cur++;
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL R1 watchdog expired: progress=%0d expected completion", cur);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  task automatic wr(input int x, input int l, input int d, inout int stalls);
    @(negedge clk);
    wr_valid = 1; wr_x = XW'(x); wr_line = LW'(l); wr_data = PW'(d);
    while (!wr_ready) begin stalls++; @(negedge clk); end
    ref_mem[l][x] = d;
    @(posedge clk);
  endtask

  task automatic row(input int y);
    for (int x = 0; x < HV + 4; x++) begin
      req_t r;
      r.x = x; r.y = y;
      r.fh = (x * 5 + y * 3) % 16;
      r.fv = (x * 11 + y) % 16;
      if (x == 3 || x == 4) begin r.fh = 15; r.fv = 15; end
      r.hs = (x == HV + 1 || x == HV + 2);
      r.vs = (y == VV);
      rq.push_back(r);
    end
  endtask

  task automatic drain();
    wait (rq.size() == 0);
    repeat (40) @(posedge clk);
  endtask

  initial begin
    int stalls;
    for (int i = 0; i < NP; i++) begin
      e_pix[i] = 0; e_val[i] = 0; e_hs[i] = 0; e_vs[i] = 0; e_tag[i] = "R10";
    end
    rst_n = 0; wr_valid = 0; wr_x = '0; wr_line = '0; wr_data = '0;
    out_x = XW'(HV); out_y = '0; frac_h = '0; frac_v = '0; hs_in = 0; vs_in = 0;
    repeat (5) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    checks++;
    if (pix_out !== '0 || pix_valid !== 1'b0 || hs_out !== 1'b0 || vs_out !== 1'b0 || wr_ready !== 1'b1) begin
      fails++;
      $display("FAIL R10 reset: pix=%0d valid=%0b hs=%0b vs=%0b ready=%0b expected 0 0 0 0 1",
               pix_out, pix_valid, hs_out, vs_out, wr_ready);
    end
    go = 1;

    stalls = 0;
    for (int l = 0; l < 4; l++)
      for (int x = 0; x < HV; x++) wr(x, l, pat(x, l), stalls);
    @(negedge clk); wr_valid = 0;
    checks++;
    if (stalls != 0) begin
      fails++;
      $display("FAIL R9 blanking writes stalled %0d times expected 0", stalls);
    end
    repeat (20) @(posedge clk);

    for (int y = 0; y <= VV; y++) begin row(y); drain(); end

    stalls = 0;
    fork
      row(0);
      begin
        for (int i = 0; i < 8; i++) wr(i, 2, (i * 53 + 17) % 256, stalls);
        @(negedge clk); wr_valid = 0;
      end
    join
    drain();
    checks++;
    if (stalls == 0) begin
      fails++;
      $display("FAIL R8 visible burst stalls=%0d expected nonzero", stalls);
    end
    row(1); row(2);
    drain();

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule